// File: doc/BRIEF.md
# IO Pad Retention Controller

This block sits between the core's per-pad output value and output enable and the pad ring. While the core is live, the two pass straight through. When the power manager signals that the core is about to lose power, a bank of per-pad transparent latches closes. The pads then keep driving the last value and direction the core gave them, while the core logic is off.

Retention starts in hardware. The power-off indication closes the latches at once, and the same indication sets a sticky control bit. Wake-up does not end retention. When the power-off indication falls, the sticky bit keeps the pads frozen until software writes 0 to it. This lets software restore the core's pad state before the pads go live again. Software can also write 1 to freeze the pads on purpose.

A parameterised exemption mask marks pads that must never be held, such as mode straps, interrupt inputs, analog, debug, clock and reset pins. These pads always follow the core.

Top module: `pad_hold_ctrl`

## Requirements
- R1: After reset, the control bit reads 0 on `cfg_rdata` and every pad follows `core_out` and `core_oe`.
- R2: While the hold is low, each retained pad (mask bit 0) shows the core's `core_out` and `core_oe` in the same cycle.
- R3: The hold is the OR of `pwr_off` and the control bit. While it is high, each retained pad keeps the value and enable it had when the hold rose, whatever the core drives.
- R4: While `pwr_off` is high, the control bit becomes 1 at the next clock edge without any software write.
- R5: When `pwr_off` falls with the control bit at 1, the bit stays 1 and the retained pads stay frozen until software clears it.
- R6: A write of 0 (`cfg_wr`=1, `cfg_wdata`=0) with `pwr_off` low clears the bit at that clock edge. From then on the retained pads show the live core values.
- R7: A write of 1 sets the control bit at that clock edge and freezes the retained pads as in R3.
- R8: Each pad whose bit in `EXEMPT_MASK` is 1 always shows `core_out` and `core_oe`, whatever the hold.
- R9: When `pwr_off` is high in the same cycle as a write of 0, `pwr_off` wins and the control bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| pwr_off | input | 1 | Sleep-entry / core power-off indication from the power manager |
| cfg_wr | input | 1 | Write strobe for the control bit |
| cfg_wdata | input | 1 | Value written to the control bit |
| cfg_rdata | output | 1 | Current value of the control bit |
| core_out | input | NPADS | Output values from the core |
| core_oe | input | NPADS | Output enables from the core |
| pad_out | output | NPADS | Output values to the pads |
| pad_oe | output | NPADS | Output enables to the pads |

## Verification
A wrong control-bit state shows on `cfg_rdata` one edge after the cause. A latch that does not close shows as soon as the core changes its data after the hold rises, in the same cycle. A latch that closes too soon, or a release that does not take, shows as pads that stay stale after the next core change. The exempt pads are compared with the core in every scenario, so a mask mix-up appears as soon as the hold first rises.

// File: rtl/pad_hold_ctrl.sv
module pad_hold_ctrl #(
  parameter int NPADS = 16,
  parameter logic [NPADS-1:0] EXEMPT_MASK = 16'h00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_off,
  input  logic             cfg_wr,
  input  logic             cfg_wdata,
  output logic             cfg_rdata,
  input  logic [NPADS-1:0] core_out,
  input  logic [NPADS-1:0] core_oe,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe
);

  logic             hold_bit;
  logic             hold;
  logic [NPADS-1:0] lat_out;
  logic [NPADS-1:0] lat_oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hold_bit <= 1'b0;
    else if (pwr_off) hold_bit <= 1'b1;
    else if (cfg_wr)  hold_bit <= cfg_wdata;

  assign hold      = pwr_off | hold_bit;
  assign cfg_rdata = hold_bit;

  always_latch
    if (!hold) begin
      lat_out = core_out;
      lat_oe  = core_oe;
    end

  assign pad_out = (core_out & EXEMPT_MASK) | (lat_out & ~EXEMPT_MASK);
  assign pad_oe  = (core_oe  & EXEMPT_MASK) | (lat_oe  & ~EXEMPT_MASK);

  assert_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (((pad_out ^ core_out) | (pad_oe ^ core_oe)) & ~EXEMPT_MASK) == '0);

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold && $past(hold) |-> $stable(pad_out & ~EXEMPT_MASK) && $stable(pad_oe & ~EXEMPT_MASK));

  assert_sleep_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> cfg_rdata);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata && !pwr_off && !(cfg_wr && !cfg_wdata) |=> cfg_rdata);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_wdata && !pwr_off |=> !cfg_rdata);

  assert_exempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ core_out) | (pad_oe ^ core_oe)) & EXEMPT_MASK) == '0);

endmodule

// File: tb/pad_hold_ctrl_tb.sv
module pad_hold_ctrl_tb_top;
  localparam int NPADS = 16;
  localparam logic [NPADS-1:0] EX = 16'h00F0;

  logic clk = 0, rst_n = 0, pwr_off = 0, cfg_wr = 0, cfg_wdata = 0;
  logic cfg_rdata;
  logic [NPADS-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
  logic [NPADS-1:0] fz_out, fz_oe;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pad_hold_ctrl #(.NPADS(NPADS), .EXEMPT_MASK(EX)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .core_out(core_out),
    .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(string req, logic [NPADS-1:0] got, logic [NPADS-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic drive(logic [NPADS-1:0] d, logic [NPADS-1:0] e);
    @(negedge clk); core_out = d; core_oe = e; #1;
  endtask

  task automatic chk_frozen(string req);
    chk(req, pad_out, (fz_out & ~EX) | (core_out & EX));
    chk(req, pad_oe,  (fz_oe  & ~EX) | (core_oe  & EX));
  endtask

  task automatic chk_live(string req);
    chk(req, pad_out, core_out);
    chk(req, pad_oe,  core_oe);
  endtask

  task automatic t_reset();
    drive(16'h1234, 16'h00FF);
    chk("R1 rdata", {15'b0, cfg_rdata}, 16'h0);
    chk_live("R1 pads");
  endtask

  task automatic t_live();
    drive(16'hA5C3, 16'hF00F); chk_live("R2 a");
    drive(16'h5A3C, 16'h0FF0); chk_live("R2 b");
  endtask

  task automatic t_sleep();
    drive(16'hBEEF, 16'hCAFE);
    fz_out = 16'hBEEF; fz_oe = 16'hCAFE;
    @(negedge clk); pwr_off = 1; #1;
    chk_frozen("R3 entry");
    step();
    chk("R4 bit set", {15'b0, cfg_rdata}, 16'h1);
    drive(16'h0123, 16'h4567); chk_frozen("R3 core change"); chk_frozen("R8 during sleep");
    drive(16'hFFFF, 16'h0000); chk_frozen("R3 oe held");
  endtask

  task automatic t_wake();
    @(negedge clk); pwr_off = 0; #1;
    step();
    chk("R5 bit stays", {15'b0, cfg_rdata}, 16'h1);
    drive(16'h7777, 16'h1111); chk_frozen("R5 still frozen");
  endtask

  task automatic t_release();
    @(negedge clk); cfg_wr = 1; cfg_wdata = 0; #1;
    chk_frozen("R6 before edge");
    @(negedge clk); cfg_wr = 0; #1;
    chk("R6 bit clear", {15'b0, cfg_rdata}, 16'h0);
    chk_live("R6 live");
    drive(16'h3C3C, 16'hC3C3); chk_live("R6 follows");
  endtask

  task automatic t_swhold();
    drive(16'h9999, 16'h6666);
    fz_out = 16'h9999; fz_oe = 16'h6666;
    @(negedge clk); cfg_wr = 1; cfg_wdata = 1; #1;
    @(negedge clk); cfg_wr = 0; #1;
    chk("R7 bit set", {15'b0, cfg_rdata}, 16'h1);
    drive(16'h0F0F, 16'hF0F0); chk_frozen("R7 frozen"); chk_frozen("R8 sw hold");
    @(negedge clk); cfg_wr = 1; cfg_wdata = 0; #1;
    @(negedge clk); cfg_wr = 0; #1;
    chk_live("R6 after sw hold");
  endtask

  task automatic t_priority();
    @(negedge clk); pwr_off = 1; cfg_wr = 1; cfg_wdata = 0; #1;
    @(negedge clk); cfg_wr = 0; pwr_off = 0; #1;
    chk("R9 pwr wins", {15'b0, cfg_rdata}, 16'h1);
    @(negedge clk); cfg_wr = 1; cfg_wdata = 0; #1;
    @(negedge clk); cfg_wr = 0; #1;
    chk("R9 clear after", {15'b0, cfg_rdata}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_live(); t_sleep(); t_wake(); t_release(); t_swhold(); t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule